// File: doc/BRIEF.md
# Timer Compare Unit with Event Trigger

This block holds a 16-bit up-counting timer and a 16-bit compare register. Both are written through a small byte-wide register port, as are a timer control register and a compare control register. When the timer and the compare value become equal, a mode field picks the action. It can drive a dedicated output latch high or low. It can raise only the compare interrupt flag. Or it can fire a special event that clears the timer and emits a one-cycle conversion-start pulse. In that last mode the compare value sets the timer period.

The timer counts either every clock or on rising edges of an external clock input. A 1, 2, 4 or 8 prescaler sits in front of it. The external input passes through a synchronizer unless the control register selects asynchronous counting, and matches are only honoured on synchronized paths. The parameter `CONV_GATED` builds a variant whose conversion-start pulse also needs the `adcEnable` input to be high.

Top module: `tmr_cmp_unit`

## Requirements
- R1: After reset every register reads 0x00, and `cmpOut`, `cmpIrq`, `ovfIrq` and `convStart` are low.
- R2: Timer control (address 0) layout: bit 0 on, bit 1 external source, bit 2 asynchronous, bit 3 oscillator enable, bits 5:4 prescale. Prescale values 0/1/2/3 advance the timer once per 1/2/4/8 increment events. A write to either timer byte restarts the prescaler.
- R3: The mode field is compare control bits 3:0. 0x8 sets `cmpOut` and 0x9 clears it, one clock edge after the timer first equals the compare value. Each match event acts once only, even while the timer stays at that value or the mode is rewritten during the match.
- R4: Mode 0xB clears both timer bytes at the match edge and gives a one-cycle `convStart` pulse. The timer then repeats with period compare+1 increments.
- R5: With `CONV_GATED`=1, a special event raises `convStart` only when `adcEnable` is high. The timer is cleared either way.
- R6: A special-event clear never sets the overflow flag, even when it happens at 0xFFFF. A natural wrap from 0xFFFF to 0 sets it (flag bit 0).
- R7: Mode 0xA sets the compare flag and leaves `cmpOut` unchanged.
- R8: Every compare action sets the compare flag (flag register bit 1, shown on `cmpIrq`). Flags stay set until a write to address 6 with a 1 in the flag's bit position.
- R9: A write of zero to compare control bits 5:0 forces `cmpOut` low. The other inactive codes (such as 0xC or 0xF) leave it unchanged.
- R10: With the external source on and oscillator enable set, the timer counts rising edges of `extClk`. Matches are honoured in synchronized mode and suppressed in asynchronous mode. With oscillator enable clear, the timer does not count.
- R11: Read map: 0 timer control (bit 7 reads 1 while on and the source is usable), 1/2 timer low/high, 3/4 compare low/high, 5 compare control (bits 7:6 read 0), 6 flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| extClk | input | 1 | External timer clock |
| adcEnable | input | 1 | Converter enable that gates `convStart` in the gated variant |
| wrEn | input | 1 | Register write strobe |
| addr | input | 3 | Register address for reads and writes |
| wrData | input | 8 | Write data byte |
| rdData | output | 8 | Read data for `addr` (combinational) |
| cmpOut | output | 1 | Compare output latch |
| cmpIrq | output | 1 | Compare interrupt flag |
| ovfIrq | output | 1 | Timer overflow interrupt flag |
| convStart | output | 1 | One-cycle conversion-start pulse |

## Verification
The hardest case to reach is a special event that lands exactly where the timer would wrap. Here the clear and the overflow compete on the same edge. The stimulus stops the timer and preloads 0xFFFE byte by byte against a compare value of 0xFFFF, then starts it and checks that no overflow flag appears. The single-action rule is also hard to observe from the ports. It is reached by stopping the timer on a value, writing the compare register to equal it, and then rewriting the mode while the match still holds.

// File: rtl/tmr_cmp_pkg.sv
package tmr_cmp_pkg;

  // register addresses
  localparam logic [2:0] ADR_TCTRL = 3'd0;
  localparam logic [2:0] ADR_TLO   = 3'd1;
  localparam logic [2:0] ADR_THI   = 3'd2;
  localparam logic [2:0] ADR_CLO   = 3'd3;
  localparam logic [2:0] ADR_CHI   = 3'd4;
  localparam logic [2:0] ADR_CCTRL = 3'd5;
  localparam logic [2:0] ADR_FLAGS = 3'd6;

  typedef enum logic [3:0] {
    MODE_OFF = 4'h0,
    MODE_SET = 4'h8,
    MODE_CLR = 4'h9,
    MODE_SWI = 4'hA,
    MODE_EVT = 4'hB
  } cmpMode_t;

  // control -> datapath strobes
  typedef struct packed {
    logic       wrLo;
    logic       wrHi;
    logic [7:0] byteIn;
    logic       evtClear;
  } tmrStrb_t;

  // timer configuration decoded from the control register
  typedef struct packed {
    logic       on;
    logic [1:0] ps;
    logic       oscEn;
    logic       noSync;
    logic       clkSrc;
  } tmrCfg_t;

endpackage

// File: rtl/tmr_cmp_dp.sv
module tmr_cmp_dp
  import tmr_cmp_pkg::*;
#(
  parameter int TMR_W       = 16,
  parameter int SYNC_STAGES = 2,
  parameter int PRE_W       = 3
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             extClk,
  input  tmrCfg_t          cfg,
  input  tmrStrb_t         strb,
  output logic [TMR_W-1:0] tmrVal,
  output logic             ovfEv
);

  localparam int HI_W = TMR_W - 8;

  logic [SYNC_STAGES-1:0] syncQ;
  logic                   extPrevS;
  logic                   riseSync, riseAsync, extRise;
  logic                   srcEv, tick;
  logic [PRE_W-1:0]       preCnt, preMask;

  // external clock: synchronizer chain plus a direct (asynchronous) edge path
  always_ff @(posedge clk) begin
    if (!rstN) begin
      syncQ    <= '0;
      extPrevS <= 1'b0;
    end else begin
      syncQ    <= {syncQ[SYNC_STAGES-2:0], extClk};
      extPrevS <= syncQ[SYNC_STAGES-1];
    end
  end

  assign riseSync  = syncQ[SYNC_STAGES-1] & ~extPrevS;
  assign riseAsync = extClk & ~syncQ[0];
  assign extRise   = cfg.noSync ? riseAsync : riseSync;

  assign srcEv   = cfg.on && (cfg.clkSrc ? (cfg.oscEn && extRise) : 1'b1);
  assign preMask = ~({PRE_W{1'b1}} << cfg.ps);
  assign tick    = srcEv && ((preCnt & preMask) == preMask);

  always_ff @(posedge clk) begin
    if (!rstN)                      preCnt <= '0;
    else if (strb.wrLo || strb.wrHi) preCnt <= '0;
    else if (srcEv)                 preCnt <= preCnt + 1'b1;
  end

  // event clear has priority over writes and counting
  always_ff @(posedge clk) begin
    if (!rstN)              tmrVal <= '0;
    else if (strb.evtClear) tmrVal <= '0;
    else if (strb.wrLo)     tmrVal[7:0] <= strb.byteIn;
    else if (strb.wrHi)     tmrVal[TMR_W-1:8] <= HI_W'(strb.byteIn);
    else if (tick)          tmrVal <= tmrVal + 1'b1;
  end

  assign ovfEv = tick && (&tmrVal) && !strb.evtClear && !strb.wrLo && !strb.wrHi;

  AST_EVT_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    strb.evtClear |=> (tmrVal == '0)); // R4

endmodule

// File: rtl/tmr_cmp_ctrl.sv
module tmr_cmp_ctrl
  import tmr_cmp_pkg::*;
#(
  parameter int TMR_W      = 16,
  parameter bit CONV_GATED = 1'b0
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             adcEnable,
  input  logic             wrEn,
  input  logic [2:0]       addr,
  input  logic [7:0]       wrData,
  output logic [7:0]       rdData,
  input  logic [TMR_W-1:0] tmrVal,
  input  logic             ovfEv,
  output tmrCfg_t          cfg,
  output tmrStrb_t         strb,
  output logic             cmpOut,
  output logic             cmpIrq,
  output logic             ovfIrq,
  output logic             convStart
);

  localparam int HI_W = TMR_W - 8;

  logic [5:0]       tctrlQ, cconQ;
  logic [TMR_W-1:0] cmpQ;
  logic             cmpFlag, ovfFlag, latchQ, matchPrev, convQ;
  logic [3:0]       mode;
  logic             modeActive, clkOk, matchNow, fire, ccWr, flagWr, running;

  assign cfg.on     = tctrlQ[0];
  assign cfg.clkSrc = tctrlQ[1];
  assign cfg.noSync = tctrlQ[2];
  assign cfg.oscEn  = tctrlQ[3];
  assign cfg.ps     = tctrlQ[5:4];

  assign mode       = cconQ[3:0];
  assign modeActive = (mode == MODE_SET) || (mode == MODE_CLR) ||
                      (mode == MODE_SWI) || (mode == MODE_EVT);
  assign clkOk      = !(cfg.clkSrc && cfg.noSync);
  assign matchNow   = modeActive && clkOk && (tmrVal == cmpQ);
  assign fire       = matchNow && !matchPrev;

  assign ccWr   = wrEn && (addr == ADR_CCTRL);
  assign flagWr = wrEn && (addr == ADR_FLAGS);

  assign strb.wrLo     = wrEn && (addr == ADR_TLO);
  assign strb.wrHi     = wrEn && (addr == ADR_THI);
  assign strb.byteIn   = wrData;
  assign strb.evtClear = fire && (mode == MODE_EVT);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      tctrlQ    <= '0;
      cconQ     <= '0;
      cmpQ      <= '0;
      matchPrev <= 1'b0;
    end else begin
      matchPrev <= matchNow;
      if (wrEn && addr == ADR_TCTRL) tctrlQ <= wrData[5:0];
      if (ccWr)                      cconQ  <= wrData[5:0];
      if (wrEn && addr == ADR_CLO)   cmpQ[7:0] <= wrData;
      if (wrEn && addr == ADR_CHI)   cmpQ[TMR_W-1:8] <= HI_W'(wrData);
    end
  end

  // output latch
  always_ff @(posedge clk) begin
    if (!rstN)                            latchQ <= 1'b0;
    else if (ccWr && wrData[5:0] == 6'd0) latchQ <= 1'b0;
    else if (fire && mode == MODE_SET)    latchQ <= 1'b1;
    else if (fire && mode == MODE_CLR)    latchQ <= 1'b0;
  end

  // sticky flags, write-one-to-clear, hardware set wins
  always_ff @(posedge clk) begin
    if (!rstN) begin
      cmpFlag <= 1'b0;
      ovfFlag <= 1'b0;
    end else begin
      if (fire)                    cmpFlag <= 1'b1;
      else if (flagWr && wrData[1]) cmpFlag <= 1'b0;
      if (ovfEv)                   ovfFlag <= 1'b1;
      else if (flagWr && wrData[0]) ovfFlag <= 1'b0;
    end
  end

  generate
    if (CONV_GATED) begin : g_gated
      always_ff @(posedge clk) begin
        if (!rstN) convQ <= 1'b0;
        else       convQ <= strb.evtClear && adcEnable;
      end
    end else begin : g_plain
      always_ff @(posedge clk) begin
        if (!rstN) convQ <= 1'b0;
        else       convQ <= strb.evtClear;
      end
    end
  endgenerate

  assign running = cfg.on && (!cfg.clkSrc || cfg.oscEn);

  always_comb begin
    rdData = 8'h00;
    case (addr)
      ADR_TCTRL: rdData = {running, 1'b0, tctrlQ};
      ADR_TLO:   rdData = tmrVal[7:0];
      ADR_THI:   rdData = 8'(tmrVal[TMR_W-1:8]);
      ADR_CLO:   rdData = cmpQ[7:0];
      ADR_CHI:   rdData = 8'(cmpQ[TMR_W-1:8]);
      ADR_CCTRL: rdData = {2'b00, cconQ};
      ADR_FLAGS: rdData = {6'd0, cmpFlag, ovfFlag};
      default:   rdData = 8'h00;
    endcase
  end

  assign cmpOut    = latchQ;
  assign cmpIrq    = cmpFlag;
  assign ovfIrq    = ovfFlag;
  assign convStart = convQ;

  AST_SET_HIGH: assert property (@(posedge clk) disable iff (!rstN)
    (fire && mode == MODE_SET && !ccWr) |=> cmpOut); // R3
  AST_CONV_GATE: assert property (@(posedge clk) disable iff (!rstN)
    convStart |-> (!CONV_GATED || $past(adcEnable))); // R5
  AST_EVT_NO_OVF: assert property (@(posedge clk) disable iff (!rstN)
    strb.evtClear |=> !$rose(ovfIrq)); // R6
  AST_SWI_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (fire && mode == MODE_SWI && !ccWr) |=> $stable(cmpOut)); // R7
  AST_FLAG_SET: assert property (@(posedge clk) disable iff (!rstN)
    fire |=> cmpIrq); // R8
  AST_CLR_LOW: assert property (@(posedge clk) disable iff (!rstN)
    (ccWr && wrData[5:0] == 6'd0) |=> !cmpOut); // R9

endmodule

// File: rtl/tmr_cmp_unit.sv
module tmr_cmp_unit
  import tmr_cmp_pkg::*;
#(
  parameter int TMR_W       = 16,
  parameter int SYNC_STAGES = 2,
  parameter int PRE_W       = 3,
  parameter bit CONV_GATED  = 1'b0
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       extClk,
  input  logic       adcEnable,
  input  logic       wrEn,
  input  logic [2:0] addr,
  input  logic [7:0] wrData,
  output logic [7:0] rdData,
  output logic       cmpOut,
  output logic       cmpIrq,
  output logic       ovfIrq,
  output logic       convStart
);

  tmrCfg_t          cfg;
  tmrStrb_t         strb;
  logic [TMR_W-1:0] tmrVal;
  logic             ovfEv;

  tmr_cmp_ctrl #(.TMR_W(TMR_W), .CONV_GATED(CONV_GATED)) u_ctrl (
    .clk(clk), .rstN(rstN), .adcEnable(adcEnable),
    .wrEn(wrEn), .addr(addr), .wrData(wrData), .rdData(rdData),
    .tmrVal(tmrVal), .ovfEv(ovfEv), .cfg(cfg), .strb(strb),
    .cmpOut(cmpOut), .cmpIrq(cmpIrq), .ovfIrq(ovfIrq), .convStart(convStart)
  );

  tmr_cmp_dp #(.TMR_W(TMR_W), .SYNC_STAGES(SYNC_STAGES), .PRE_W(PRE_W)) u_dp (
    .clk(clk), .rstN(rstN), .extClk(extClk), .cfg(cfg), .strb(strb),
    .tmrVal(tmrVal), .ovfEv(ovfEv)
  );

endmodule

// File: tb/sim_tmr_cmp_unit.sv
module sim_tmr_cmp_unit;

  localparam int S_RD = 0, S_OUT = 1, S_CIRQ = 2, S_OIRQ = 3, S_CONV = 4;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       extClk = 1'b0;
  logic       adcEnable = 1'b1;
  logic       wrEn = 1'b0;
  logic [2:0] addr = 3'd0;
  logic [7:0] wrData = 8'd0;
  logic [7:0] rdData;
  logic       cmpOut, cmpIrq, ovfIrq, convStart;

  int cyc = 0;
  int nChecks = 0;
  int nFail = 0;

  typedef struct {
    int          due;
    int          sig;
    logic [15:0] exp;
    string       tag;
  } item_t;
  item_t q[$];

  always #2 clk = ~clk;

  tmr_cmp_unit #(.CONV_GATED(1'b1)) u0 (
    .clk(clk), .rstN(rstN), .extClk(extClk), .adcEnable(adcEnable),
    .wrEn(wrEn), .addr(addr), .wrData(wrData), .rdData(rdData),
    .cmpOut(cmpOut), .cmpIrq(cmpIrq), .ovfIrq(ovfIrq), .convStart(convStart)
  );

  function automatic logic [15:0] actual(int s);
    case (s)
      S_RD:    return {8'd0, rdData};
      S_OUT:   return {15'd0, cmpOut};
      S_CIRQ:  return {15'd0, cmpIrq};
      S_OIRQ:  return {15'd0, ovfIrq};
      default: return {15'd0, convStart};
    endcase
  endfunction

  // monitor: one sample per cycle, 1 ns after the rising edge
  initial forever begin
    @(posedge clk);
    cyc++;
    #1;
    for (int i = q.size() - 1; i >= 0; i--) begin
      if (q[i].due == cyc) begin
        logic [15:0] a;
        a = actual(q[i].sig);
        nChecks++;
        if (a !== q[i].exp) begin
          nFail++;
          $display("FAIL %s sig=%0d cycle=%0d actual=%0h expected=%0h",
                   q[i].tag, q[i].sig, cyc, a, q[i].exp);
        end
        q.delete(i);
      end
    end
  end

  task automatic want(input int d, input int s, input logic [15:0] e, input string t);
    item_t it;
    it.due = cyc + d; it.sig = s; it.exp = e; it.tag = t;
    q.push_back(it);
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    wrEn = 1'b1; addr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic pulses(input int n);
    for (int i = 0; i < n; i++) begin
      extClk = 1'b1; tick(3);
      extClk = 1'b0; tick(3);
    end
  endtask

  initial begin
    #400000;
    nFail++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", nChecks, nFail);
    $finish;
  end

  initial begin
    tick(3);
    rstN = 1'b1;
    // R1 reset state
    want(1, S_RD, 16'h00, "R1 tctrl");
    want(1, S_OUT, 0, "R1 cmpOut");
    want(1, S_CIRQ, 0, "R1 cmpIrq");
    want(1, S_OIRQ, 0, "R1 ovfIrq");
    want(1, S_CONV, 0, "R1 convStart");
    tick(2);

    // R2 divide by 4
    wr(0, 8'h21);
    addr = 3'd1;
    want(40, S_RD, 10, "R2 div4 a");
    want(43, S_RD, 10, "R2 div4 b");
    want(44, S_RD, 11, "R2 div4 c");
    tick(45);
    // R2 divide by 8
    wr(0, 8'h00); wr(1, 8'h00); wr(2, 8'h00);
    wr(0, 8'h31);
    addr = 3'd1;
    want(79, S_RD, 9, "R2 div8 a");
    want(80, S_RD, 10, "R2 div8 b");
    tick(82);

    // R3 set on match, divide by 1
    wr(0, 8'h00); wr(1, 8'h00); wr(2, 8'h00);
    wr(3, 8'h10); wr(4, 8'h00); wr(5, 8'h08);
    wr(0, 8'h01);
    want(16, S_OUT, 0, "R3 before match");
    want(17, S_OUT, 1, "R3 set high");
    want(17, S_CIRQ, 1, "R8 flag on set");
    tick(20);

    // R3 clear on match with a stopped timer, then no refire
    wr(0, 8'h00);
    wr(6, 8'h02);
    want(1, S_CIRQ, 0, "R8 w1c clear");
    wr(5, 8'h09);
    wr(1, 8'h20); wr(2, 8'h00);
    want(1, S_OUT, 1, "R3 latch held");
    wr(3, 8'h20);
    want(1, S_OUT, 0, "R3 clear low");
    want(1, S_CIRQ, 1, "R8 flag on clear");
    tick(2);
    wr(6, 8'h02);
    wr(5, 8'h08);
    want(3, S_OUT, 0, "R3 no refire on held match");
    want(3, S_CIRQ, 0, "R3 no second flag");
    tick(4);

    // R9 and R11: inactive codes hold, zero forces low
    wr(3, 8'h21);
    wr(1, 8'h21);
    want(1, S_OUT, 1, "R3 set again");
    wr(5, 8'hFF);
    want(1, S_RD, 16'h3F, "R11 cctrl upper bits zero");
    want(1, S_OUT, 1, "R9 other off code holds");
    tick(2);
    wr(5, 8'h00);
    want(1, S_OUT, 0, "R9 zero forces low");
    tick(2);

    // R7 software interrupt keeps latch
    wr(5, 8'h08); wr(3, 8'h30); wr(1, 8'h30);
    want(1, S_OUT, 1, "R7 preset high");
    wr(6, 8'h02);
    wr(5, 8'h0A); wr(3, 8'h31); wr(1, 8'h31);
    want(1, S_CIRQ, 1, "R7 flag set");
    want(1, S_OUT, 1, "R7 latch unchanged a");
    want(2, S_OUT, 1, "R7 latch unchanged b");
    tick(3);

    // R4 / R5 special event period
    wr(0, 8'h00); wr(6, 8'h03); wr(5, 8'h0B);
    wr(3, 8'h05); wr(4, 8'h00); wr(1, 8'h00); wr(2, 8'h00);
    wr(0, 8'h01);
    addr = 3'd1;
    want(5, S_RD, 5, "R4 at compare");
    want(6, S_RD, 0, "R4 timer cleared");
    want(7, S_RD, 1, "R4 restart");
    want(5, S_CONV, 0, "R4 no pulse early");
    want(6, S_CONV, 1, "R4 pulse");
    want(7, S_CONV, 0, "R4 pulse one cycle");
    want(12, S_CONV, 1, "R4 period compare+1");
    want(6, S_CIRQ, 1, "R8 flag on event");
    want(12, S_OIRQ, 0, "R6 no ovf from event");
    tick(13);
    adcEnable = 1'b0;
    want(5, S_CONV, 0, "R5 gated off");
    want(5, S_RD, 0, "R5 timer still cleared");
    tick(8);

    // R6 event at 0xFFFF vs natural wrap
    wr(0, 8'h00); wr(6, 8'h03);
    wr(3, 8'hFF); wr(4, 8'hFF); wr(1, 8'hFE); wr(2, 8'hFF);
    wr(0, 8'h01);
    addr = 3'd1;
    want(1, S_RD, 16'hFF, "R6 at top");
    want(2, S_RD, 0, "R6 event clear at top");
    want(2, S_CIRQ, 1, "R6 event fired");
    want(3, S_OIRQ, 0, "R6 event no ovf");
    tick(4);
    wr(0, 8'h00); wr(5, 8'h00); wr(6, 8'h03);
    wr(1, 8'hFE); wr(2, 8'hFF);
    wr(0, 8'h01);
    want(1, S_OIRQ, 0, "R6 before wrap");
    want(2, S_OIRQ, 1, "R6 natural wrap");
    tick(3);
    wr(6, 8'h01);
    want(1, S_OIRQ, 0, "R8 ovf w1c");
    tick(2);

    // R10 external synchronized source
    wr(0, 8'h00); wr(5, 8'h00);
    wr(3, 8'h03); wr(4, 8'h00); wr(1, 8'h00); wr(2, 8'h00);
    wr(6, 8'h03); wr(5, 8'h0A);
    wr(0, 8'h0B);
    want(1, S_RD, 16'h8B, "R11 running bit");
    tick(2);
    pulses(5); tick(4);
    addr = 3'd1;
    want(1, S_RD, 5, "R10 sync count");
    want(1, S_CIRQ, 1, "R10 sync match");
    tick(2);
    // asynchronous: counts but match suppressed
    wr(0, 8'h00); wr(1, 8'h00); wr(2, 8'h00); wr(6, 8'h02);
    wr(0, 8'h0F);
    pulses(5); tick(4);
    addr = 3'd1;
    want(1, S_RD, 5, "R10 async count");
    want(1, S_CIRQ, 0, "R10 async no match");
    tick(2);
    // oscillator off: no count, status bit clear
    wr(0, 8'h03);
    want(1, S_RD, 16'h03, "R11 not running");
    tick(2);
    pulses(2); tick(4);
    addr = 3'd1;
    want(1, S_RD, 5, "R10 osc off holds");
    tick(4);

    if (q.size() != 0) begin
      nFail++;
      $display("FAIL pending items=%0d expected=0", q.size());
    end
    $display("TB_RESULT checks=%0d failures=%0d", nChecks, nFail);
    $finish;
  end

endmodule